// File: doc/BRIEF.md
# DDR3 Command and Address Decoder

This block watches the command and address pins of a DDR3 memory device on each rising clock edge. It sorts every sampled cycle into one command class and splits the address bus into bank, row and column fields. It also decodes the address bits that carry a second meaning: bit 10 selects auto-precharge on reads and writes, and it selects all banks on a precharge. Bit 12 asks for an on-the-fly burst chop. All of these results appear on registered outputs one cycle after sampling.

The block keeps its own copies of the mode register fields that change how later commands are read: burst length mode, burst order, power-down exit speed, and whether the mask pin serves as a termination strobe. A mode register write is visible on these copies from the next cycle. The burst-chop output of every later read or write is computed from the copy in force at that command. The block suits a memory model, a protocol monitor or a controller self-check. Timing rules, storage and the data path are left to other blocks.

Top module: `dram_cmd_decode`

## Requirements
- R1: While rst_n is low every output is 0. This includes the mode copies, so after reset the decoder assumes fixed burst length 8, sequential order, slow exit and the mask function.
- R2: A cycle with cke high and cs_n high is a deselect. cmd_vld is 0 one cycle later, and bank, row and col keep their values whatever the other pins carry.
- R3: With cke high and cs_n low, the code {ras_n,cas_n,we_n} is decoded into a one-hot cmd_vld one cycle after sampling. The codes are 011 activate (bit 0), 101 read (bit 1), 100 write (bit 2), 010 precharge (bit 3), 000 mode register write (bit 4) and 001 refresh (bit 5). At most one bit is ever set.
- R4: With cke high and cs_n low, the codes 110 and 111 decode as no-operation (cmd_vld bit 6).
- R5: An activate loads bank from ba and row from the whole address bus.
- R6: A read or a write loads bank from ba and col from addr[COL_W-1:0]. It sets ap to addr[10]. ap is 0 on every other cycle.
- R7: A precharge loads bank from ba and sets pre_all to addr[10]. pre_all is 0 on every other cycle.
- R8: On a read or write, bc is set as follows. If the burst length copy is 01 (chosen per command), bc is the inverse of addr[12]. If the copy is 10 (fixed chop), bc is 1. If it is 00 or 11, bc is 0. bc is 0 on every non-read, non-write cycle.
- R9: A mode register write with ba=0 loads mr_bl from addr[1:0], mr_bt from addr[3] and mr_pd_fast from addr[12]. With ba=1 it loads mr_tdqs from addr[11]. Any other ba leaves the copies unchanged, and the copies change at no other time.
- R10: A cycle with cke low produces cmd_vld 0 one cycle later. If cs_n is low and the code is 001, the decoder raises sr_flag (self-refresh). Otherwise it raises pd_flag (power-down). The two flags are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe command bit |
| cas_n | input | 1 | Column strobe command bit |
| we_n | input | 1 | Write enable command bit |
| cke | input | 1 | Clock enable; low means low-power entry or stay |
| ba | input | BANK_W | Bank address, also the mode register select |
| addr | input | ROW_W | Row/column address and mode op-code |
| cmd_vld | output | 7 | One-hot decoded command |
| bank | output | BANK_W | Bank of the last activate, read, write or precharge |
| row | output | ROW_W | Row of the last activate |
| col | output | COL_W | Column of the last read or write |
| ap | output | 1 | Auto-precharge on this read or write |
| bc | output | 1 | Burst chopped on this read or write |
| pre_all | output | 1 | This precharge covers all banks |
| pd_flag | output | 1 | Power-down entry or stay |
| sr_flag | output | 1 | Self-refresh entry |
| mr_bl | output | 2 | Burst length mode copy |
| mr_bt | output | 1 | Burst order copy (0 sequential) |
| mr_pd_fast | output | 1 | Power-down exit copy (1 fast) |
| mr_tdqs | output | 1 | Mask pin serves as termination strobe |

## Verification
The hardest case to reach is the burst-chop result. It depends on a mode register write that may have happened many cycles earlier, and it must use the copy as it stood before any write in the same cycle. The stimulus programs each of the four burst length codes in turn. After each one it issues reads and writes with addr[12] both high and low, including a read in the cycle right after the mode write. The random phase also produces mode writes to all eight ba values between commands, so the shadow copy keeps changing under the reads and writes.

// File: rtl/dram_cmd_pkg.sv
package dram_cmd_pkg;

    localparam int NCMD    = 7;
    localparam int CI_ACT  = 0;
    localparam int CI_RD   = 1;
    localparam int CI_WR   = 2;
    localparam int CI_PRE  = 3;
    localparam int CI_MRS  = 4;
    localparam int CI_REF  = 5;
    localparam int CI_NOP  = 6;

    // pin positions whose meaning depends on the command
    localparam int AP_BIT  = 10;
    localparam int BC_BIT  = 12;

    typedef enum logic [1:0] {
        BLM_FIX8 = 2'b00,
        BLM_OTF  = 2'b01,
        BLM_FIX4 = 2'b10,
        BLM_RSV  = 2'b11
    } blm_e;

    typedef struct packed {
        logic [1:0] bl;
        logic       bt;
        logic       pd_fast;
        logic       tdqs;
    } mode_t;

endpackage

// File: rtl/cmd_classify.sv
module cmd_classify
    import dram_cmd_pkg::*;
(
    input  logic            cs_n,
    input  logic            ras_n,
    input  logic            cas_n,
    input  logic            we_n,
    input  logic            cke,
    output logic [NCMD-1:0] hit,
    output logic            pd_hit,
    output logic            sr_hit
);
    logic [2:0] code;
    logic       ref_code;

    assign code     = {ras_n, cas_n, we_n};
    assign ref_code = !cs_n && (code == 3'b001);

    always_comb begin
        hit = '0;
        if (cke && !cs_n) begin
            unique case (code)
                3'b011:  hit[CI_ACT] = 1'b1;
                3'b101:  hit[CI_RD]  = 1'b1;
                3'b100:  hit[CI_WR]  = 1'b1;
                3'b010:  hit[CI_PRE] = 1'b1;
                3'b000:  hit[CI_MRS] = 1'b1;
                3'b001:  hit[CI_REF] = 1'b1;
                default: hit[CI_NOP] = 1'b1;
            endcase
        end
    end

    assign sr_hit = !cke && ref_code;
    assign pd_hit = !cke && !ref_code;
endmodule

// File: rtl/mode_shadow.sv
module mode_shadow
    import dram_cmd_pkg::*;
#(
    parameter int BANK_W  = 3,
    parameter int MR0_SEL = 0,
    parameter int MR1_SEL = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mrs,
    input  logic [BANK_W-1:0] sel,
    input  logic [1:0]        op_bl,
    input  logic              op_bt,
    input  logic              op_pdx,
    input  logic              op_tdqs,
    output mode_t             mode_q
);
    localparam logic [BANK_W-1:0] SEL0 = BANK_W'(MR0_SEL);
    localparam logic [BANK_W-1:0] SEL1 = BANK_W'(MR1_SEL);

    mode_t mode_d;

    always_comb begin
        mode_d = mode_q;
        if (mrs && sel == SEL0) begin
            mode_d.bl      = op_bl;
            mode_d.bt      = op_bt;
            mode_d.pd_fast = op_pdx;
        end
        if (mrs && sel == SEL1) begin
            mode_d.tdqs = op_tdqs;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= '0;
        else        mode_q <= mode_d;
    end
endmodule

// File: rtl/dram_cmd_decode.sv
module dram_cmd_decode
    import dram_cmd_pkg::*;
#(
    parameter int BANK_W = 3,
    parameter int ROW_W  = 15,
    parameter int COL_W  = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic                ras_n,
    input  logic                cas_n,
    input  logic                we_n,
    input  logic                cke,
    input  logic [BANK_W-1:0]   ba,
    input  logic [ROW_W-1:0]    addr,
    output logic [NCMD-1:0]     cmd_vld,
    output logic [BANK_W-1:0]   bank,
    output logic [ROW_W-1:0]    row,
    output logic [COL_W-1:0]    col,
    output logic                ap,
    output logic                bc,
    output logic                pre_all,
    output logic                pd_flag,
    output logic                sr_flag,
    output logic [1:0]          mr_bl,
    output logic                mr_bt,
    output logic                mr_pd_fast,
    output logic                mr_tdqs
);
    typedef struct packed {
        logic [NCMD-1:0]   cmd;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic              ap;
        logic              bc;
        logic              all;
        logic              pd;
        logic              sr;
    } out_t;

    out_t            out_d, out_q;
    logic [NCMD-1:0] hit;
    logic            pd_hit, sr_hit;
    logic            chop;
    mode_t           mode_q;

    cmd_classify u_cls (
        .cs_n   (cs_n),
        .ras_n  (ras_n),
        .cas_n  (cas_n),
        .we_n   (we_n),
        .cke    (cke),
        .hit    (hit),
        .pd_hit (pd_hit),
        .sr_hit (sr_hit)
    );

    mode_shadow #(.BANK_W(BANK_W)) u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .mrs     (hit[CI_MRS]),
        .sel     (ba),
        .op_bl   (addr[1:0]),
        .op_bt   (addr[3]),
        .op_pdx  (addr[BC_BIT]),
        .op_tdqs (addr[11]),
        .mode_q  (mode_q)
    );

    // chop decision uses the copy in force before this cycle's edge
    always_comb begin
        unique case (blm_e'(mode_q.bl))
            BLM_OTF:  chop = !addr[BC_BIT];
            BLM_FIX4: chop = 1'b1;
            default:  chop = 1'b0;
        endcase
    end

    always_comb begin
        out_d     = out_q;
        out_d.cmd = hit;
        out_d.ap  = 1'b0;
        out_d.bc  = 1'b0;
        out_d.all = 1'b0;
        out_d.pd  = pd_hit;
        out_d.sr  = sr_hit;
        if (hit[CI_ACT]) begin
            out_d.bank = ba;
            out_d.row  = addr;
        end
        if (hit[CI_RD] || hit[CI_WR]) begin
            out_d.bank = ba;
            out_d.col  = addr[COL_W-1:0];
            out_d.ap   = addr[AP_BIT];
            out_d.bc   = chop;
        end
        if (hit[CI_PRE]) begin
            out_d.bank = ba;
            out_d.all  = addr[AP_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign cmd_vld    = out_q.cmd;
    assign bank       = out_q.bank;
    assign row        = out_q.row;
    assign col        = out_q.col;
    assign ap         = out_q.ap;
    assign bc         = out_q.bc;
    assign pre_all    = out_q.all;
    assign pd_flag    = out_q.pd;
    assign sr_flag    = out_q.sr;
    assign mr_bl      = mode_q.bl;
    assign mr_bt      = mode_q.bt;
    assign mr_pd_fast = mode_q.pd_fast;
    assign mr_tdqs    = mode_q.tdqs;
endmodule

// File: rtl/dram_cmd_decode_chk.sv
module dram_cmd_decode_chk
    import dram_cmd_pkg::*;
#(
    parameter int BANK_W = 3,
    parameter int ROW_W  = 15,
    parameter int COL_W  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic              cke,
    input logic [NCMD-1:0]   cmd_vld,
    input logic [BANK_W-1:0] bank,
    input logic [ROW_W-1:0]  row,
    input logic [COL_W-1:0]  col,
    input logic              ap,
    input logic              bc,
    input logic              pre_all,
    input logic              pd_flag,
    input logic              sr_flag,
    input logic [1:0]        mr_bl,
    input logic              mr_bt,
    input logic              mr_pd_fast,
    input logic              mr_tdqs
);
    logic mrs_pins;
    assign mrs_pins = cke && !cs_n && !ras_n && !cas_n && !we_n;

    // R3
    cmd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_vld));

    // R2
    desel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && cs_n) |=> (cmd_vld == '0 && $stable(bank) && $stable(row) && $stable(col)));

    // R10
    lowpwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> (cmd_vld == '0 && (pd_flag != sr_flag)));

    // R6
    ap_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ap |-> (cmd_vld[CI_RD] || cmd_vld[CI_WR]));

    // R8
    bc_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bc |-> (cmd_vld[CI_RD] || cmd_vld[CI_WR]));

    // R7
    preall_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pre_all |-> cmd_vld[CI_PRE]);

    // R9
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mrs_pins |=> ($stable(mr_bl) && $stable(mr_bt) && $stable(mr_pd_fast) && $stable(mr_tdqs)));
endmodule

bind dram_cmd_decode dram_cmd_decode_chk #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .cke(cke), .cmd_vld(cmd_vld), .bank(bank), .row(row),
    .col(col), .ap(ap), .bc(bc), .pre_all(pre_all), .pd_flag(pd_flag),
    .sr_flag(sr_flag), .mr_bl(mr_bl), .mr_bt(mr_bt),
    .mr_pd_fast(mr_pd_fast), .mr_tdqs(mr_tdqs)
);

// File: tb/dram_cmd_decode_tb.sv
`timescale 1ns/1ps
module dram_cmd_decode_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
    logic [2:0]  ba = '0;
    logic [14:0] addr = '0;
    logic [6:0]  cmd_vld;
    logic [2:0]  bank;
    logic [14:0] row;
    logic [9:0]  col;
    logic        ap, bc, pre_all, pd_flag, sr_flag;
    logic [1:0]  mr_bl;
    logic        mr_bt, mr_pd_fast, mr_tdqs;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // expected model state
    logic [6:0]  e_cmd = '0;
    logic [2:0]  e_bank = '0;
    logic [14:0] e_row = '0;
    logic [9:0]  e_col = '0;
    logic        e_ap = 0, e_bc = 0, e_all = 0, e_pd = 0, e_sr = 0;
    logic [1:0]  e_bl = '0;
    logic        e_bt = 0, e_pf = 0, e_tdqs = 0;

    always #5 clk = ~clk;

    dram_cmd_decode dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .cke(cke), .ba(ba), .addr(addr), .cmd_vld(cmd_vld),
        .bank(bank), .row(row), .col(col), .ap(ap), .bc(bc), .pre_all(pre_all),
        .pd_flag(pd_flag), .sr_flag(sr_flag), .mr_bl(mr_bl), .mr_bt(mr_bt),
        .mr_pd_fast(mr_pd_fast), .mr_tdqs(mr_tdqs)
    );

    task automatic chk(input string req, input string fld,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, fld, act, exp);
        end
    endtask

    function automatic logic exp_chop(input logic [1:0] blm, input logic a12);
        if (blm == 2'b01) return !a12;
        if (blm == 2'b10) return 1'b1;
        return 1'b0;
    endfunction

    // drive at a negedge, update the model, check at the next negedge
    task automatic step(input logic i_cs, input logic [2:0] code, input logic i_cke,
                        input logic [2:0] b, input logic [14:0] a);
        string tag;
        cs_n = i_cs; {ras_n, cas_n, we_n} = code; cke = i_cke; ba = b; addr = a;
        e_cmd = '0; e_ap = 0; e_bc = 0; e_all = 0; e_pd = 0; e_sr = 0;
        tag = "R3";
        if (!i_cke) begin
            tag = "R10";
            if (!i_cs && code == 3'b001) e_sr = 1; else e_pd = 1;
        end else if (i_cs) begin
            tag = "R2";
        end else begin
            case (code)
                3'b011: begin e_cmd = 7'b0000001; e_bank = b; e_row = a; tag = "R5"; end
                3'b101, 3'b100: begin
                    e_cmd = (code == 3'b101) ? 7'b0000010 : 7'b0000100;
                    e_bank = b; e_col = a[9:0]; e_ap = a[10];
                    e_bc = exp_chop(e_bl, a[12]); tag = "R6";
                end
                3'b010: begin e_cmd = 7'b0001000; e_bank = b; e_all = a[10]; tag = "R7"; end
                3'b000: begin
                    e_cmd = 7'b0010000; tag = "R9";
                    if (b == 3'd0) begin e_bl = a[1:0]; e_bt = a[3]; e_pf = a[12]; end
                    if (b == 3'd1) e_tdqs = a[11];
                end
                3'b001: e_cmd = 7'b0100000;
                default: begin e_cmd = 7'b1000000; tag = "R4"; end
            endcase
        end
        @(negedge clk);
        chk(tag, "cmd_vld", 32'(cmd_vld), 32'(e_cmd));
        chk(tag, "bank", 32'(bank), 32'(e_bank));
        chk(tag, "row", 32'(row), 32'(e_row));
        chk(tag, "col", 32'(col), 32'(e_col));
        chk("R6", "ap", 32'(ap), 32'(e_ap));
        chk("R8", "bc", 32'(bc), 32'(e_bc));
        chk("R7", "pre_all", 32'(pre_all), 32'(e_all));
        chk("R10", "pd_flag", 32'(pd_flag), 32'(e_pd));
        chk("R10", "sr_flag", 32'(sr_flag), 32'(e_sr));
        chk("R9", "mode", 32'({mr_bl, mr_bt, mr_pd_fast, mr_tdqs}),
            32'({e_bl, e_bt, e_pf, e_tdqs}));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'd20231);
        // R1 reset state, driven pins busy
        cs_n = 0; {ras_n, cas_n, we_n} = 3'b000; addr = '1; ba = 3'd0;
        repeat (3) @(negedge clk);
        chk("R1", "cmd_vld", 32'(cmd_vld), 0);
        chk("R1", "fields", 32'({bank, ap, bc, pre_all, pd_flag, sr_flag}), 0);
        chk("R1", "mode", 32'({mr_bl, mr_bt, mr_pd_fast, mr_tdqs}), 0);
        cs_n = 1;
        rst_n = 1'b1;
        @(negedge clk);

        // directed: activate, precharge single/all (R5, R7)
        step(0, 3'b011, 1, 3'd5, 15'h7abc);
        step(0, 3'b010, 1, 3'd2, 15'h0400);
        step(0, 3'b010, 1, 3'd6, 15'h0000);
        // R2 deselect with busy pins keeps fields
        step(1, 3'b011, 1, 3'd1, 15'h1234);
        // R4 no-operation codes
        step(0, 3'b110, 1, 3'd0, 15'h0000);
        step(0, 3'b111, 1, 3'd0, 15'h0000);
        // R8 each burst length mode, read right after the mode write
        for (int m = 0; m < 4; m++) begin
            step(0, 3'b000, 1, 3'd0, 15'(m) | 15'h1008);
            step(0, 3'b101, 1, 3'd3, 15'h0400 | 15'(m));
            step(0, 3'b100, 1, 3'd4, 15'h1000 | 15'(m));
            step(0, 3'b101, 1, 3'd7, 15'h1400);
        end
        // R9 mode register 1 and an unselected register
        step(0, 3'b000, 1, 3'd1, 15'h0800);
        step(0, 3'b000, 1, 3'd2, 15'h7fff);
        step(0, 3'b000, 1, 3'd3, 15'h0003);
        // R10 self-refresh and power-down
        step(0, 3'b001, 0, 3'd0, 15'h0000);
        step(1, 3'b001, 0, 3'd0, 15'h0000);
        step(0, 3'b011, 0, 3'd4, 15'h0fff);
        step(0, 3'b001, 1, 3'd0, 15'h0000);

        // constrained random
        for (int i = 0; i < 600; i++) begin
            logic rc, rk;
            rc = ($urandom % 4) == 0;
            rk = ($urandom % 8) != 0;
            step(rc, 3'($urandom), rk, 3'($urandom), 15'($urandom));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule